// File: doc/BRIEF.md
# Strobed Input Port Channel

This block is the receive side of one 8-bit parallel port that works with a handshake. A peripheral puts a byte on the data pins and pulses an active-low strobe. While the strobe is low, the byte is copied into an input latch and an input-buffer-full flag rises. When the strobe returns high, the channel raises an interrupt request toward the CPU, provided the channel's interrupt-enable flop is set. The CPU reads the port. The falling edge of its read strobe drops the interrupt, and the rising edge of the read strobe drops the buffer-full flag, so the peripheral can tell when it may send the next byte.

The strobe and the read strobe arrive asynchronously. Each passes through a synchroniser before its edges are detected. The interrupt-enable flop is written by a single-bit set/reset command that addresses one control-port bit position. A mode write clears the enable flop and the handshake state.

Top module: `strobed_in_port`

## Requirements
- R1: While `rst` is high, `ibf`, `intr` and `dout` are all 0, and the enable flop is cleared.
- R2: While the synchronised strobe is low, `dout` follows `din`. Once the strobe has returned high, `dout` holds the last captured byte, even if `din` changes.
- R3: A low strobe sets `ibf`. The flag is visible 3 clock edges after `stb_n` falls.
- R4: `ibf` clears 3 edges after a rising edge of `rd_n` that occurs while `port_sel` is 1. A read performed with `port_sel` at 0 changes neither `ibf` nor `intr`.
- R5: When the strobe returns high with the enable flop set, `intr` rises 3 edges after `stb_n` rises.
- R6: `intr` clears 3 edges after a falling edge of `rd_n` that occurs while `port_sel` is 1. At that point `ibf` is still 1.
- R7: A set/reset command is a one-cycle pulse on `bsr_wr`. `bsr_bit` gives the bit index, and `bsr_val` gives the value (1 sets, 0 clears). The command changes the enable flop only when `bsr_bit` equals `INTE_BIT` (default 4). Any other index leaves the flop untouched.
- R8: A one-cycle `mode_wr` pulse clears the enable flop, `ibf` and the pending request on the next edge.
- R9: A strobe taken while the enable flop is clear leaves `intr` at 0. If the flop is then set while `ibf` is still 1, `intr` rises 1 edge after the set command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| stb_n | input | 1 | Peripheral strobe, active low, asynchronous |
| din | input | 8 | Peripheral data |
| rd_n | input | 1 | CPU read strobe, active low, asynchronous |
| port_sel | input | 1 | High when the read addresses this port |
| bsr_wr | input | 1 | Single-bit set/reset command strobe |
| bsr_bit | input | 3 | Bit index of the set/reset command |
| bsr_val | input | 1 | 1 sets the bit, 0 clears it |
| mode_wr | input | 1 | Mode write pulse |
| dout | output | 8 | Latched input byte |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Interrupt request |

## Verification
The strobe and the read strobe each pass through two synchroniser flops and then a state flop. Results that depend on them (`ibf` rising, `dout` capture, `intr` rising, `intr` and `ibf` clearing) are therefore due 3 edges after the pin changes. Set/reset and mode commands take effect 1 edge after the pulse. The bench drives every input on the falling clock edge, waits exactly that number of falling edges, and samples there. Checks that an output holds its value are made only after enough further edges for any wrongly passed change to show.

// File: rtl/strobed_in_port.sv
module strobed_in_port #(
  parameter int W        = 8,
  parameter int SYNC     = 2,
  parameter int INTE_BIT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb_n,
  input  logic [W-1:0] din,
  input  logic         rd_n,
  input  logic         port_sel,
  input  logic         bsr_wr,
  input  logic [2:0]   bsr_bit,
  input  logic         bsr_val,
  input  logic         mode_wr,
  output logic [W-1:0] dout,
  output logic         ibf,
  output logic         intr
);

  localparam logic [2:0] SEL = 3'(INTE_BIT);

  logic [SYNC-1:0] stb_sh, rd_sh;
  logic            stb_prev, rd_prev, pend, inte;

  wire stb_s    = stb_sh[SYNC-1];
  wire rd_s     = rd_sh[SYNC-1];
  wire stb_rise = stb_s & ~stb_prev;
  wire rd_rise  = port_sel & rd_s & ~rd_prev;
  wire rd_fall  = port_sel & ~rd_s & rd_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_sh   <= '1;
      rd_sh    <= '1;
      stb_prev <= 1'b1;
      rd_prev  <= 1'b1;
    end else begin
      stb_sh   <= {stb_sh[SYNC-2:0], stb_n};
      rd_sh    <= {rd_sh[SYNC-2:0], rd_n};
      stb_prev <= stb_s;
      rd_prev  <= rd_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (!stb_s) dout <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || mode_wr) begin
      ibf  <= 1'b0;
      pend <= 1'b0;
      inte <= 1'b0;
    end else begin
      if (!stb_s)       ibf <= 1'b1;
      else if (rd_rise) ibf <= 1'b0;
      if (stb_rise)     pend <= 1'b1;
      else if (rd_fall) pend <= 1'b0;
      if (bsr_wr && bsr_bit == SEL) inte <= bsr_val;
    end
  end

  assign intr = pend & ibf & inte & stb_s;

endmodule

module strobed_in_port_chk #(parameter int W = 8) (
  input logic         clk,
  input logic         rst,
  input logic         stb_s,
  input logic         stb_rise,
  input logic         rd_rise,
  input logic         rd_fall,
  input logic         mode_wr,
  input logic [W-1:0] dout,
  input logic         ibf,
  input logic         intr
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!ibf && !intr && dout == '0));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stb_s |=> $stable(dout));

  // R3
  ibf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!stb_s && !mode_wr) |=> ibf);

  // R4
  ibf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_rise && stb_s) |=> !ibf);

  // R6
  intr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_fall && !stb_rise) |=> !intr);

  // R8
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (!ibf && !intr));

endmodule

bind strobed_in_port strobed_in_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .stb_s(stb_s), .stb_rise(stb_rise),
  .rd_rise(rd_rise), .rd_fall(rd_fall), .mode_wr(mode_wr),
  .dout(dout), .ibf(ibf), .intr(intr)
);

// File: tb/test_strobed_in_port.sv
module test_strobed_in_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stb_n = 1'b1, rd_n = 1'b1, port_sel = 1'b0;
  logic       bsr_wr = 1'b0, bsr_val = 1'b0, mode_wr = 1'b0;
  logic [2:0] bsr_bit = 3'd0;
  logic [7:0] din = 8'd0, dout;
  logic       ibf, intr;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  strobed_in_port i_strobed_in_port (
    .clk(clk), .rst(rst), .stb_n(stb_n), .din(din), .rd_n(rd_n),
    .port_sel(port_sel), .bsr_wr(bsr_wr), .bsr_bit(bsr_bit),
    .bsr_val(bsr_val), .mode_wr(mode_wr), .dout(dout), .ibf(ibf), .intr(intr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bsr(input int b, input bit v);
    bsr_bit = 3'(b); bsr_val = v; bsr_wr = 1'b1;
    wait_n(1);
    bsr_wr = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] d);
    din = d; stb_n = 1'b0; wait_n(3);
    stb_n = 1'b1; wait_n(3);
  endtask

  task automatic cpu_read();
    port_sel = 1'b1; rd_n = 1'b0; wait_n(3);
    rd_n = 1'b1; wait_n(3);
    port_sel = 1'b0;
  endtask

  initial begin
    wait_n(3);
    chk("R1 ibf", ibf, 0); chk("R1 intr", intr, 0); chk("R1 dout", dout, 0);
    rst = 1'b0;
    wait_n(1);
    bsr(4, 1'b1);

    for (int k = 0; k < 16; k++) begin
      logic [7:0] d;
      d = 8'(k * 37 + 3);
      din = d; stb_n = 1'b0; wait_n(3);
      chk("R3 ibf set", ibf, 1); chk("R2 capture", dout, d); chk("R5 intr low", intr, 0);
      stb_n = 1'b1; wait_n(3);
      chk("R5 intr rise", intr, 1);
      din = ~d; wait_n(3);
      chk("R2 hold", dout, d);
      if (k % 2 == 1) begin
        rd_n = 1'b0; wait_n(3); rd_n = 1'b1; wait_n(3);
        chk("R4 unselected ibf", ibf, 1); chk("R4 unselected intr", intr, 1);
      end
      port_sel = 1'b1; rd_n = 1'b0; wait_n(3);
      chk("R6 intr clear", intr, 0); chk("R6 ibf kept", ibf, 1);
      rd_n = 1'b1; wait_n(3);
      chk("R4 ibf clear", ibf, 0);
      port_sel = 1'b0;
    end

    for (int b = 0; b < 8; b++) begin
      bsr(b, 1'b0);
      strobe(8'(b));
      chk("R7 bit select", intr, (b == 4) ? 0 : 1);
      cpu_read();
      bsr(4, 1'b1);
    end

    bsr(4, 1'b0);
    strobe(8'hA5);
    chk("R9 masked", intr, 0); chk("R9 ibf", ibf, 1);
    bsr(4, 1'b1);
    chk("R9 unmask", intr, 1);

    mode_wr = 1'b1; wait_n(1); mode_wr = 1'b0;
    chk("R8 ibf", ibf, 0); chk("R8 intr", intr, 0);
    strobe(8'h3C);
    chk("R8 inte cleared", intr, 0); chk("R8 ibf after", ibf, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule